// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit decides, for every instruction presented to it, whether control leaves the sequential path, and it produces the program counter to fetch next. It reads a 6-bit opcode, a 2-bit jump-kind selector, two register operands, the carry flag, a 16-bit immediate and the current PC. The opcode range 111000 to 111111 holds the control-transfer instructions. Any other opcode simply advances the PC by one word.

Conditional branches compare the two operands as equal or not equal, as unsigned values (greater, greater-or-equal) or as two's-complement values (greater, greater-or-equal). One opcode tests only the carry flag. One opcode is shared by three unconditional transfers, and the jump-kind selector picks among them: jump to the immediate, jump to the address held in operand A, and call. A call also asks for a write of the return address into link register 19.

The immediate is an absolute target: it is zero-extended, and the PC is not added to it. All results are registered, so they appear one clock after the inputs are sampled. Flushing of younger instructions on a taken transfer is left to the surrounding pipeline.

Top module: `brt_unit`

## Requirements
- R1: While reset is low, and right after it goes low with no clock edge, taken_o, next_pc_o, link_we_o and link_addr_o are all zero.
- R2: Opcode 111000 is taken when opa_i equals opb_i. Opcode 111001 is taken when they differ.
- R3: Opcode 111010 is taken when opa_i > opb_i as unsigned values. Opcode 111011 is taken when opa_i >= opb_i as unsigned values.
- R4: Opcode 111100 is taken when opa_i > opb_i as two's-complement values. Opcode 111101 is taken when opa_i >= opb_i as two's-complement values.
- R5: Opcode 111110 is taken exactly when carry_i is 1. The operands are ignored.
- R6: Opcode 111111 with kind_i 00 is always taken. Its target is imm_i zero-extended to 32 bits.
- R7: Opcode 111111 with kind_i 01 is always taken. Its target is opa_i.
- R8: Opcode 111111 with kind_i 10 is taken with the zero-extended immediate as target and raises link_we_o. link_idx_o is always 19, and link_addr_o is always pc_i + 4.
- R9: Opcode 111111 with kind_i 11 is not taken, next_pc_o is pc_i + 4, and link_we_o stays 0.
- R10: A taken conditional branch targets the zero-extended immediate whatever pc_i is. A branch that is not taken gives pc_i + 4.
- R11: Every opcode outside 111000 to 111111 gives taken_o = 0, next_pc_o = pc_i + 4 and link_we_o = 0, whatever kind_i is.
- R12: taken_o, next_pc_o, link_we_o and link_addr_o reflect the inputs sampled at the previous rising clock edge, and do not change before that edge.
- R13: pc_i + 4 wraps modulo 2^32, so pc_i = 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 6 | Instruction opcode |
| kind_i | input | 2 | Jump-kind selector for opcode 111111: 00 immediate, 01 register, 10 call, 11 reserved |
| opa_i | input | 32 | Operand A, also the register jump target |
| opb_i | input | 32 | Operand B |
| carry_i | input | 1 | Carry flag |
| imm_i | input | 16 | Absolute target immediate |
| pc_i | input | 32 | PC of the current instruction |
| taken_o | output | 1 | Control transfer taken |
| next_pc_o | output | 32 | Next PC to fetch |
| link_we_o | output | 1 | Write request for the link register |
| link_idx_o | output | 5 | Index of the link register (19) |
| link_addr_o | output | 32 | Return address, pc_i + 4 |

## Verification
Every registered result is due exactly one rising edge after its inputs are applied. The bench drives each vector on a falling edge and compares on the next falling edge, which lies half a period after the capturing edge. One directed case samples shortly before that capturing edge, to show that nothing has moved yet (R12). The reset case drops rst_n between edges and compares at once, because the clear does not wait for a clock. The signed and unsigned vectors reuse the same bit patterns, so that the two orderings must disagree.

// File: rtl/brt_pkg.sv
package brt_pkg;

  localparam int unsigned OPW = 6;

  // control-transfer opcodes; all share the top three bits 111
  localparam logic [OPW-1:0] OP_BEQ  = 6'b111000;
  localparam logic [OPW-1:0] OP_BNE  = 6'b111001;
  localparam logic [OPW-1:0] OP_BGTU = 6'b111010;
  localparam logic [OPW-1:0] OP_BGEU = 6'b111011;
  localparam logic [OPW-1:0] OP_BGTS = 6'b111100;
  localparam logic [OPW-1:0] OP_BGES = 6'b111101;
  localparam logic [OPW-1:0] OP_BCY  = 6'b111110;
  localparam logic [OPW-1:0] OP_JMP  = 6'b111111;

  typedef enum logic [1:0] {
    JK_IMM  = 2'b00,
    JK_REG  = 2'b01,
    JK_CALL = 2'b10,
    JK_RSVD = 2'b11
  } jkind_e;

  typedef struct packed {
    logic taken;    // leave the sequential path
    logic use_reg;  // target comes from operand A
    logic link;     // write return address
  } brt_dec_t;

endpackage

// File: rtl/brt_cond.sv
module brt_cond
  import brt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OPW-1:0]  op_i,
  input  logic [1:0]      kind_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic            carry_i,
  output brt_dec_t        dec_o
);

  logic eq, gtu, gts;

  always_comb begin
    eq  = (opa_i == opb_i);
    gtu = (opa_i > opb_i);
    gts = ($signed(opa_i) > $signed(opb_i));
  end

  always_comb begin
    dec_o = '0;
    unique case (op_i)
      OP_BEQ:  dec_o.taken = eq;
      OP_BNE:  dec_o.taken = !eq;
      OP_BGTU: dec_o.taken = gtu;
      OP_BGEU: dec_o.taken = gtu | eq;
      OP_BGTS: dec_o.taken = gts;
      OP_BGES: dec_o.taken = gts | eq;
      OP_BCY:  dec_o.taken = carry_i;
      OP_JMP: begin
        unique case (jkind_e'(kind_i))
          JK_IMM:  dec_o.taken = 1'b1;
          JK_REG:  begin dec_o.taken = 1'b1; dec_o.use_reg = 1'b1; end
          JK_CALL: begin dec_o.taken = 1'b1; dec_o.link = 1'b1; end
          default: dec_o = '0;
        endcase
      end
      default: dec_o = '0;
    endcase
  end

endmodule

// File: rtl/brt_target.sv
module brt_target
  import brt_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IMMW    = 16,
  parameter int unsigned PC_STEP = 4
) (
  input  brt_dec_t        dec_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] ret_addr_o
);

  localparam int unsigned PADW = XLEN - IMMW;
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  logic [XLEN-1:0] imm_abs;

  generate
    if (PADW > 0) begin : g_pad
      assign imm_abs = {{PADW{1'b0}}, imm_i};
    end else begin : g_nopad
      assign imm_abs = imm_i[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    ret_addr_o = pc_i + STEP;
    if (!dec_i.taken)        next_pc_o = ret_addr_o;
    else if (dec_i.use_reg)  next_pc_o = opa_i;
    else                     next_pc_o = imm_abs;
  end

endmodule

// File: rtl/brt_unit.sv
module brt_unit
  import brt_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IMMW     = 16,
  parameter int unsigned REGW     = 5,
  parameter int unsigned LINK_REG = 19,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      op_i,
  input  logic [1:0]      kind_i,
  input  logic [31:0]     opa_i,
  input  logic [31:0]     opb_i,
  input  logic            carry_i,
  input  logic [15:0]     imm_i,
  input  logic [31:0]     pc_i,
  output logic            taken_o,
  output logic [31:0]     next_pc_o,
  output logic            link_we_o,
  output logic [4:0]      link_idx_o,
  output logic [31:0]     link_addr_o
);

  // ---- reset: asserted asynchronously, released through a flop chain
  logic [SYNC_LEN-1:0] sync_q;
  logic                rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_ok = sync_q[SYNC_LEN-1];

  // ---- decision and target
  brt_dec_t        dec_d;
  logic [XLEN-1:0] next_d, ret_d;

  brt_cond #(.XLEN(XLEN)) u_cond (
    .op_i    (op_i),
    .kind_i  (kind_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .carry_i (carry_i),
    .dec_o   (dec_d)
  );

  brt_target #(.XLEN(XLEN), .IMMW(IMMW), .PC_STEP(PC_STEP)) u_tgt (
    .dec_i      (dec_d),
    .opa_i      (opa_i),
    .imm_i      (imm_i),
    .pc_i       (pc_i),
    .next_pc_o  (next_d),
    .ret_addr_o (ret_d)
  );

  // ---- output register
  logic            taken_q, link_q;
  logic [XLEN-1:0] next_q, ret_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      taken_q <= 1'b0;
      link_q  <= 1'b0;
      next_q  <= '0;
      ret_q   <= '0;
    end else begin
      taken_q <= dec_d.taken;
      link_q  <= dec_d.link;
      next_q  <= next_d;
      ret_q   <= ret_d;
    end
  end

  assign taken_o     = taken_q;
  assign link_we_o   = link_q;
  assign next_pc_o   = next_q;
  assign link_addr_o = ret_q;
  assign link_idx_o  = REGW'(LINK_REG);

  // ---- assertions
  // R11: opcodes outside the transfer range advance sequentially
  a_r11_seq_path: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_i[5:3] != 3'b111) |=> (!taken_o && !link_we_o && next_pc_o == $past(pc_i) + 32'd4));

  // R8: a call raises the link write with the return address
  a_r8_call_link: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_i == 6'b111111 && kind_i == 2'b10) |=>
      (taken_o && link_we_o && link_addr_o == $past(pc_i) + 32'd4
       && next_pc_o == {16'h0, $past(imm_i)}));

  // R8: link write only comes with a taken transfer
  a_r8_link_taken: assert property (@(posedge clk) disable iff (!rst_ok)
    link_we_o |-> taken_o);

  // R7: register jump lands on operand A
  a_r7_reg_jump: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_i == 6'b111111 && kind_i == 2'b01) |=> (taken_o && next_pc_o == $past(opa_i)));

  // R5: carry branch follows the flag
  a_r5_carry: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_i == 6'b111110) |=> (taken_o == $past(carry_i)));

  // R9: reserved jump kind does nothing
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_i == 6'b111111 && kind_i == 2'b11) |=> (!taken_o && !link_we_o));

endmodule

// File: tb/brt_unit_tb.sv
`timescale 1ns/1ps
module brt_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  op;
  logic [1:0]  kind;
  logic [31:0] opa, opb, pc;
  logic        carry;
  logic [15:0] imm;
  logic        taken, link_we;
  logic [31:0] next_pc, link_addr;
  logic [4:0]  link_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  brt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .kind_i(kind), .opa_i(opa),
    .opb_i(opb), .carry_i(carry), .imm_i(imm), .pc_i(pc),
    .taken_o(taken), .next_pc_o(next_pc), .link_we_o(link_we),
    .link_idx_o(link_idx), .link_addr_o(link_addr)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  op;
    logic [1:0]  kind;
    logic [31:0] a;
    logic [31:0] b;
    logic        c;
    logic [15:0] imm;
    logic [31:0] pc;
    logic        tk;
    logic [31:0] nx;
    logic        lw;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    // R2
    '{4'd2, 6'b111000, 2'b00, 32'd5, 32'd5, 1'b0, 16'h0040, 32'h100, 1'b1, 32'h40, 1'b0},
    '{4'd2, 6'b111000, 2'b00, 32'd5, 32'd6, 1'b0, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    '{4'd2, 6'b111001, 2'b00, 32'd5, 32'd6, 1'b0, 16'h0040, 32'h100, 1'b1, 32'h40, 1'b0},
    '{4'd2, 6'b111001, 2'b00, 32'd5, 32'd5, 1'b0, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    // R3
    '{4'd3, 6'b111010, 2'b00, 32'hFFFFFFFF, 32'd1, 1'b0, 16'h0040, 32'h100, 1'b1, 32'h40, 1'b0},
    '{4'd3, 6'b111010, 2'b00, 32'd1, 32'd1, 1'b0, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    '{4'd3, 6'b111011, 2'b00, 32'd1, 32'd1, 1'b0, 16'h0040, 32'h100, 1'b1, 32'h40, 1'b0},
    '{4'd3, 6'b111011, 2'b00, 32'd0, 32'd1, 1'b0, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    // R4
    '{4'd4, 6'b111100, 2'b00, 32'd1, 32'hFFFFFFFF, 1'b0, 16'h0040, 32'h100, 1'b1, 32'h40, 1'b0},
    '{4'd4, 6'b111100, 2'b00, 32'hFFFFFFFF, 32'd1, 1'b0, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    '{4'd4, 6'b111101, 2'b00, 32'h80000000, 32'h80000000, 1'b0, 16'h0040, 32'h100, 1'b1, 32'h40, 1'b0},
    '{4'd4, 6'b111101, 2'b00, 32'h80000000, 32'h7FFFFFFF, 1'b0, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    // R5
    '{4'd5, 6'b111110, 2'b00, 32'd1, 32'd2, 1'b1, 16'h0040, 32'h100, 1'b1, 32'h40, 1'b0},
    '{4'd5, 6'b111110, 2'b00, 32'd3, 32'd3, 1'b0, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    // R6
    '{4'd6, 6'b111111, 2'b00, 32'd7, 32'd9, 1'b0, 16'hFFFF, 32'h100, 1'b1, 32'h0000FFFF, 1'b0},
    // R7
    '{4'd7, 6'b111111, 2'b01, 32'h12345678, 32'd0, 1'b0, 16'h0040, 32'h100, 1'b1, 32'h12345678, 1'b0},
    // R8
    '{4'd8, 6'b111111, 2'b10, 32'd0, 32'd0, 1'b0, 16'h0200, 32'h100, 1'b1, 32'h200, 1'b1},
    // R9
    '{4'd9, 6'b111111, 2'b11, 32'd0, 32'd0, 1'b1, 16'h0200, 32'h100, 1'b0, 32'h104, 1'b0},
    // R11
    '{4'd11, 6'b000000, 2'b00, 32'd4, 32'd4, 1'b1, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    '{4'd11, 6'b100000, 2'b10, 32'd4, 32'd4, 1'b1, 16'h0040, 32'h100, 1'b0, 32'h104, 1'b0},
    // R13
    '{4'd13, 6'b111000, 2'b00, 32'd0, 32'd1, 1'b0, 16'h0040, 32'hFFFFFFFC, 1'b0, 32'h0, 1'b0},
    // R10
    '{4'd10, 6'b111001, 2'b00, 32'd1, 32'd2, 1'b0, 16'h0010, 32'h2000, 1'b1, 32'h10, 1'b0}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op = v.op; kind = v.kind; opa = v.a; opb = v.b;
    carry = v.c; imm = v.imm; pc = v.pc;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(VEC[16]);
    #9;
    // R1: outputs held at zero during reset
    chk("R1", "taken", {31'd0, taken}, 32'd0);
    chk("R1", "next_pc", next_pc, 32'd0);
    chk("R1", "link_we", {31'd0, link_we}, 32'd0);
    chk("R1", "link_addr", link_addr, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].req);
      drive(VEC[i]);
      @(negedge clk);
      chk(tag, "taken", {31'd0, taken}, {31'd0, VEC[i].tk});
      chk(tag, "next_pc", next_pc, VEC[i].nx);
      chk(tag, "link_we", {31'd0, link_we}, {31'd0, VEC[i].lw});
      chk(tag, "link_addr", link_addr, VEC[i].pc + 32'd4);
    end

    // R8: link index constant
    chk("R8", "link_idx", {27'd0, link_idx}, 32'd19);

    // R12: nothing moves before the capturing edge
    drive(VEC[1]);            // not taken
    @(negedge clk);
    drive(VEC[0]);            // taken
    #1;
    chk("R12", "taken early", {31'd0, taken}, 32'd0);
    chk("R12", "next_pc early", next_pc, 32'h104);
    @(negedge clk);
    chk("R12", "taken after edge", {31'd0, taken}, 32'd1);
    chk("R12", "next_pc after edge", next_pc, 32'h40);

    // R1: asynchronous clear between edges
    drive(VEC[16]);
    @(negedge clk);
    chk("R1", "call before reset", {31'd0, link_we}, 32'd1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1", "async taken", {31'd0, taken}, 32'd0);
    chk("R1", "async link_we", {31'd0, link_we}, 32'd0);
    chk("R1", "async next_pc", next_pc, 32'd0);
    chk("R1", "async link_addr", link_addr, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule